// File: doc/BRIEF.md
# MI Coherence Private Cache Controller

This block is the private first-level cache controller of one node. Coherence with a home directory uses two stable line states: invalid and modified. The processor side offers load, instruction fetch, store and atomic operations through a valid/ready port, and each completed operation returns one data word. On the network side the controller issues exclusive-read requests and writebacks on an outgoing request channel. It sends data replies on an outgoing response channel. It consumes forwarded requests and writeback acknowledgements on one incoming channel and data replies on another. Each channel is an in-order virtual channel.

A small set-associative array holds the tag, presence and one data word per line. A single transient record follows the one operation that may be outstanding at a time. That operation is either a miss waiting for data or a victim waiting for its writeback to finish. During a writeback the transient record keeps a copy of the victim data. A forwarded exclusive request that overtakes the writeback is therefore served from that copy, and the controller then waits for a negative acknowledgement instead of a positive one. Messages that arrive in a state where they make no sense are dropped, and they set a sticky error flag.

Top module: `mi_l1_ctrl`

## Requirements
- R1: After reset the controller has no completion pending, no outgoing message, the error flag at 0 and every line invalid, so the first access to any address misses.
- R2: A processor request that misses (op 0 load, 1 fetch, 2 store, 3 atomic) while no transient operation is outstanding and a way is free is accepted. The next cycle it emits a request of type 0 (exclusive read) with the line address, sender NODE_ID and destination equal to the low DIR_BITS address bits. It gives no completion yet.
- R3: Data (incoming type 0) for the pending miss installs the line as modified and completes the request one cycle later. A load or fetch returns the received word. A store or atomic writes its own word and returns it.
- R4: A request that hits a modified line completes one cycle after acceptance with no outgoing message. Load and fetch return the stored word. Store and atomic overwrite the word and return the new value.
- R5: While a miss or writeback is outstanding, a processor request to that line, or any further miss, is held (ready low). At most one outgoing request leaves in any two consecutive cycles.
- R6: A forwarded exclusive request (forward type 0) to a modified line sends, one cycle later, a data response carrying the line word to the requester id given in the message. The line becomes invalid, so the next access misses.
- R7: A miss in a full set is not accepted. Instead, the way chosen by that set's round-robin pointer is evicted: a request of type 1 (writeback) carrying its address and word leaves, and the way is freed. The processor request is accepted later, once the writeback has ended.
- R8: A writeback acknowledgement (forward type 1) for the line being written back ends the writeback.
- R9: A forwarded exclusive request to the line being written back is answered with the saved victim word. After that, a negative acknowledgement (forward type 2) ends the writeback.
- R10: A forwarded exclusive request for a line whose miss is outstanding is held at the head of its channel until the data has arrived.
- R11: An incoming message with no matching state (an acknowledgement with no writeback, data with no pending miss) is consumed and sets the sticky error flag, which stays set until reset.
- R12: If several channels are valid in the same cycle, the incoming response is served first, then an actionable forward, then the processor request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Processor request consumed this cycle |
| cpu_req_op | input | 2 | 0 load, 1 fetch, 2 store, 3 atomic |
| cpu_req_addr | input | LA_W | Line address |
| cpu_req_wdata | input | DATA_W | Store word |
| cpu_done | output | 1 | Completion pulse |
| cpu_done_data | output | DATA_W | Completion word |
| req_out_valid | output | 1 | Outgoing request present |
| req_out_type | output | 1 | 0 exclusive read, 1 writeback |
| req_out_addr | output | LA_W | Request line address |
| req_out_src | output | ID_W | Sender id |
| req_out_dest | output | ID_W | Home directory id |
| req_out_data | output | DATA_W | Writeback word |
| rsp_out_valid | output | 1 | Outgoing data response present |
| rsp_out_addr | output | LA_W | Response line address |
| rsp_out_src | output | ID_W | Sender id |
| rsp_out_dest | output | ID_W | Requester id |
| rsp_out_data | output | DATA_W | Response word |
| fwd_in_valid | input | 1 | Forwarded message present |
| fwd_in_ready | output | 1 | Forwarded message consumed |
| fwd_in_type | input | 2 | 0 exclusive request, 1 ack, 2 nack |
| fwd_in_addr | input | LA_W | Forward line address |
| fwd_in_src | input | ID_W | Requester id |
| rsp_in_valid | input | 1 | Incoming response present |
| rsp_in_ready | output | 1 | Incoming response consumed |
| rsp_in_type | input | 1 | 0 data, 1 not allowed |
| rsp_in_addr | input | LA_W | Response line address |
| rsp_in_data | input | DATA_W | Response word |
| proto_err | output | 1 | Sticky protocol error |

## Verification
The bench builds the controller with two sets of two ways, 8-bit line addresses, 16-bit data, a 2-bit node id and one directory bit. With so few ways, two misses fill a set, and a third miss to that set forces eviction by the round-robin pointer within a handful of cycles. Both writeback endings (plain acknowledgement, and a forward that overtakes the writeback and is followed by a negative acknowledgement) are reached on successive victims in the same set, so the pointer is seen to advance.

// File: rtl/mi_pkg.sv
package mi_pkg;

    typedef enum logic [1:0] {
        OP_LOAD   = 2'd0,
        OP_FETCH  = 2'd1,
        OP_STORE  = 2'd2,
        OP_ATOMIC = 2'd3
    } cpu_op_e;

    typedef enum logic {
        RQ_GETX = 1'b0,
        RQ_PUTX = 1'b1
    } req_msg_e;

    typedef enum logic [1:0] {
        FW_GETX   = 2'd0,
        FW_ACK    = 2'd1,
        FW_NACK   = 2'd2
    } fwd_msg_e;

    localparam logic RSP_DATA = 1'b0;

    // transient record states
    typedef enum logic [1:0] {
        TS_IS = 2'd0,
        TS_IM = 2'd1,
        TS_MI = 2'd2,
        TS_II = 2'd3
    } tstate_e;

    function automatic logic op_is_store(logic [1:0] op);
        return (op == OP_STORE) || (op == OP_ATOMIC);
    endfunction

endpackage

// File: rtl/mi_line_array.sv
module mi_line_array #(
    parameter int SETS   = 4,
    parameter int WAYS   = 2,
    parameter int TAG_W  = 10,
    parameter int DATA_W = 32,
    parameter int SET_W  = 2,
    parameter int WAY_W  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SET_W-1:0]  lk_set,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              hit,
    output logic [WAY_W-1:0]  hit_way,
    output logic [DATA_W-1:0] hit_data,
    output logic              has_free,
    output logic [WAY_W-1:0]  free_way,
    input  logic [WAY_W-1:0]  vic_way,
    output logic [TAG_W-1:0]  vic_tag,
    output logic [DATA_W-1:0] vic_data,
    input  logic              wr_en,
    input  logic [SET_W-1:0]  wr_set,
    input  logic [WAY_W-1:0]  wr_way,
    input  logic              wr_valid,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);
    logic              v_q   [SETS][WAYS];
    logic [TAG_W-1:0]  tag_q [SETS][WAYS];
    logic [DATA_W-1:0] dat_q [SETS][WAYS];
    logic [WAYS-1:0]   match;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    v_q[s][w] <= 1'b0;
        end else if (wr_en) begin
            v_q[wr_set][wr_way] <= wr_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_set][wr_way] <= wr_tag;
            dat_q[wr_set][wr_way] <= wr_data;
        end
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign match[w] = v_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
    end

    always_comb begin
        hit      = |match;
        hit_way  = '0;
        hit_data = '0;
        has_free = 1'b0;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) begin
                hit_way  = WAY_W'(w);
                hit_data = dat_q[lk_set][w];
            end
            if (!v_q[lk_set][w]) begin
                has_free = 1'b1;
                free_way = WAY_W'(w);
            end
        end
    end

    assign vic_tag  = tag_q[lk_set][vic_way];
    assign vic_data = dat_q[lk_set][vic_way];

    // R2: a line is allocated only on a miss, so no set holds a tag twice
    a_r2_unique_tag: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match));

endmodule

// File: rtl/mi_victim_rr.sv
module mi_victim_rr #(
    parameter int SETS  = 4,
    parameter int WAYS  = 2,
    parameter int SET_W = 2,
    parameter int WAY_W = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SET_W-1:0] rd_set,
    output logic [WAY_W-1:0] ptr,
    input  logic             adv,
    input  logic [SET_W-1:0] adv_set
);
    logic [WAY_W-1:0] ptr_q [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
        end else if (adv) begin
            ptr_q[adv_set] <= (ptr_q[adv_set] == WAY_W'(WAYS - 1)) ? '0
                              : ptr_q[adv_set] + WAY_W'(1);
        end
    end

    assign ptr = ptr_q[rd_set];

    // R7: the pointer never names a way beyond the set
    a_r7_ptr_range: assert property (@(posedge clk) disable iff (rst)
        32'(ptr) < WAYS);

endmodule

// File: rtl/mi_l1_ctrl.sv
module mi_l1_ctrl
    import mi_pkg::*;
#(
    parameter int LA_W     = 12,
    parameter int DATA_W   = 32,
    parameter int SETS     = 4,
    parameter int WAYS     = 2,
    parameter int ID_W     = 2,
    parameter int NODE_ID  = 0,
    parameter int DIR_BITS = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req_valid,
    output logic              cpu_req_ready,
    input  logic [1:0]        cpu_req_op,
    input  logic [LA_W-1:0]   cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_done_data,
    output logic              req_out_valid,
    output logic              req_out_type,
    output logic [LA_W-1:0]   req_out_addr,
    output logic [ID_W-1:0]   req_out_src,
    output logic [ID_W-1:0]   req_out_dest,
    output logic [DATA_W-1:0] req_out_data,
    output logic              rsp_out_valid,
    output logic [LA_W-1:0]   rsp_out_addr,
    output logic [ID_W-1:0]   rsp_out_src,
    output logic [ID_W-1:0]   rsp_out_dest,
    output logic [DATA_W-1:0] rsp_out_data,
    input  logic              fwd_in_valid,
    output logic              fwd_in_ready,
    input  logic [1:0]        fwd_in_type,
    input  logic [LA_W-1:0]   fwd_in_addr,
    input  logic [ID_W-1:0]   fwd_in_src,
    input  logic              rsp_in_valid,
    output logic              rsp_in_ready,
    input  logic              rsp_in_type,
    input  logic [LA_W-1:0]   rsp_in_addr,
    input  logic [DATA_W-1:0] rsp_in_data,
    output logic              proto_err
);
    localparam int SET_W = $clog2(SETS);
    localparam int TAG_W = LA_W - SET_W;
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

    // transient record
    logic              tb_busy, tb_busy_n;
    tstate_e           tb_st, tb_st_n;
    logic [LA_W-1:0]   tb_addr, tb_addr_n;
    logic [WAY_W-1:0]  tb_way, tb_way_n;
    logic              tb_wr, tb_wr_n;
    logic [DATA_W-1:0] tb_wd, tb_wd_n;
    logic [DATA_W-1:0] tb_data, tb_data_n;

    // registered outputs, next values
    logic              done_n, rq_v_n, rq_t_n, rs_v_n, err_n;
    logic [DATA_W-1:0] done_d_n, rq_d_n, rs_d_n;
    logic [LA_W-1:0]   rq_a_n, rs_a_n;
    logic [ID_W-1:0]   rs_dst_n;

    // array interface
    logic [LA_W-1:0]   lk_addr;
    logic [SET_W-1:0]  lk_set;
    logic              hit, has_free, wr_en, wr_valid, rr_adv;
    logic [WAY_W-1:0]  hit_way, free_way, vic_way, wr_way;
    logic [DATA_W-1:0] hit_data, vic_data, wr_data;
    logic [TAG_W-1:0]  vic_tag, wr_tag;
    logic [SET_W-1:0]  wr_set;

    logic fwd_hit_tb, cpu_hit_tb, fwd_hold, fwd_act;

    assign fwd_hit_tb = tb_busy && (tb_addr == fwd_in_addr);
    assign cpu_hit_tb = tb_busy && (tb_addr == cpu_req_addr);
    assign fwd_hold   = fwd_hit_tb && (tb_st == TS_IS || tb_st == TS_IM)
                        && (fwd_in_type == FW_GETX);
    assign fwd_act    = fwd_in_valid && !fwd_hold && !rsp_in_valid;
    assign lk_addr    = fwd_act ? fwd_in_addr : cpu_req_addr;
    assign lk_set     = lk_addr[SET_W-1:0];

    mi_line_array #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .DATA_W(DATA_W),
                    .SET_W(SET_W), .WAY_W(WAY_W)) u_array (
        .clk, .rst, .lk_set, .lk_tag(lk_addr[LA_W-1:SET_W]),
        .hit, .hit_way, .hit_data, .has_free, .free_way,
        .vic_way, .vic_tag, .vic_data,
        .wr_en, .wr_set, .wr_way, .wr_valid, .wr_tag, .wr_data
    );

    mi_victim_rr #(.SETS(SETS), .WAYS(WAYS), .SET_W(SET_W), .WAY_W(WAY_W)) u_rr (
        .clk, .rst, .rd_set(lk_set), .ptr(vic_way), .adv(rr_adv), .adv_set(lk_set)
    );

    always_comb begin
        {tb_busy_n, tb_st_n, tb_addr_n, tb_way_n} = {tb_busy, tb_st, tb_addr, tb_way};
        {tb_wr_n, tb_wd_n, tb_data_n}             = {tb_wr, tb_wd, tb_data};
        {done_n, rq_v_n, rq_t_n, rs_v_n}          = '0;
        {done_d_n, rq_d_n, rs_d_n, rq_a_n, rs_a_n, rs_dst_n} = '0;
        err_n         = proto_err;
        rsp_in_ready  = 1'b0;
        fwd_in_ready  = 1'b0;
        cpu_req_ready = 1'b0;
        {wr_en, wr_valid, rr_adv} = '0;
        wr_set  = lk_set;
        wr_way  = hit_way;
        wr_tag  = lk_addr[LA_W-1:SET_W];
        wr_data = cpu_req_wdata;

        if (rsp_in_valid) begin
            rsp_in_ready = 1'b1;
            if (rsp_in_type == RSP_DATA && tb_busy && tb_addr == rsp_in_addr
                && (tb_st == TS_IS || tb_st == TS_IM)) begin
                wr_en     = 1'b1;
                wr_valid  = 1'b1;
                wr_set    = tb_addr[SET_W-1:0];
                wr_way    = tb_way;
                wr_tag    = tb_addr[LA_W-1:SET_W];
                wr_data   = tb_wr ? tb_wd : rsp_in_data;
                done_n    = 1'b1;
                done_d_n  = wr_data;
                tb_busy_n = 1'b0;
            end else begin
                err_n = 1'b1;
            end
        end else if (fwd_act) begin
            fwd_in_ready = 1'b1;
            case (fwd_in_type)
                FW_GETX: begin
                    if (fwd_hit_tb && tb_st == TS_MI) begin
                        {rs_v_n, rs_a_n, rs_dst_n, rs_d_n} = {1'b1, fwd_in_addr, fwd_in_src, tb_data};
                        tb_st_n = TS_II;
                    end else if (!fwd_hit_tb && hit) begin
                        {rs_v_n, rs_a_n, rs_dst_n, rs_d_n} = {1'b1, fwd_in_addr, fwd_in_src, hit_data};
                        wr_en = 1'b1;
                    end else begin
                        err_n = 1'b1;
                    end
                end
                FW_ACK:  if (fwd_hit_tb && tb_st == TS_MI) tb_busy_n = 1'b0;
                         else err_n = 1'b1;
                FW_NACK: if (fwd_hit_tb && tb_st == TS_II) tb_busy_n = 1'b0;
                         else err_n = 1'b1;
                default: err_n = 1'b1;
            endcase
        end else if (cpu_req_valid && !cpu_hit_tb) begin
            if (hit) begin
                cpu_req_ready = 1'b1;
                done_n        = 1'b1;
                done_d_n      = op_is_store(cpu_req_op) ? cpu_req_wdata : hit_data;
                wr_en         = op_is_store(cpu_req_op);
                wr_valid      = 1'b1;
            end else if (!tb_busy && has_free) begin
                cpu_req_ready = 1'b1;
                wr_en         = 1'b1;
                wr_valid      = 1'b1;
                wr_way        = free_way;
                {rq_v_n, rq_t_n, rq_a_n} = {1'b1, RQ_GETX, cpu_req_addr};
                tb_busy_n = 1'b1;
                tb_st_n   = op_is_store(cpu_req_op) ? TS_IM : TS_IS;
                tb_addr_n = cpu_req_addr;
                tb_way_n  = free_way;
                tb_wr_n   = op_is_store(cpu_req_op);
                tb_wd_n   = cpu_req_wdata;
            end else if (!tb_busy) begin
                // replacement of the round-robin victim, request stays queued
                wr_en  = 1'b1;
                wr_way = vic_way;
                rr_adv = 1'b1;
                {rq_v_n, rq_t_n, rq_a_n, rq_d_n} = {1'b1, RQ_PUTX, vic_tag, lk_set, vic_data};
                tb_busy_n = 1'b1;
                tb_st_n   = TS_MI;
                tb_addr_n = {vic_tag, lk_set};
                tb_data_n = vic_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tb_busy <= 1'b0;
            tb_st   <= TS_IS;
            {cpu_done, req_out_valid, rsp_out_valid, proto_err} <= '0;
            {req_out_type, req_out_addr, req_out_data} <= '0;
            {rsp_out_addr, rsp_out_dest, rsp_out_data, cpu_done_data} <= '0;
        end else begin
            tb_busy <= tb_busy_n;
            tb_st   <= tb_st_n;
            {cpu_done, cpu_done_data}                       <= {done_n, done_d_n};
            {req_out_valid, req_out_type, req_out_addr}     <= {rq_v_n, rq_t_n, rq_a_n};
            req_out_data                                    <= rq_d_n;
            {rsp_out_valid, rsp_out_addr, rsp_out_dest}     <= {rs_v_n, rs_a_n, rs_dst_n};
            rsp_out_data                                    <= rs_d_n;
            proto_err                                       <= err_n;
        end
    end

    always_ff @(posedge clk) begin
        {tb_addr, tb_way, tb_wr, tb_wd, tb_data} <= {tb_addr_n, tb_way_n, tb_wr_n, tb_wd_n, tb_data_n};
    end

    assign req_out_src  = ID_W'(NODE_ID);
    assign rsp_out_src  = ID_W'(NODE_ID);
    assign req_out_dest = ID_W'(req_out_addr[DIR_BITS-1:0]);

    a_r12_rsp_first: assert property (@(posedge clk) disable iff (rst)
        rsp_in_valid |-> (!fwd_in_ready && !cpu_req_ready));
    a_r11_err_sticky: assert property (@(posedge clk) disable iff (rst)
        proto_err |=> proto_err);
    a_r5_single_miss: assert property (@(posedge clk) disable iff (rst)
        req_out_valid |=> !req_out_valid);
    a_r2_no_early_done: assert property (@(posedge clk) disable iff (rst)
        req_out_valid |-> !cpu_done);
    a_r6_one_event: assert property (@(posedge clk) disable iff (rst)
        rsp_out_valid |-> (!req_out_valid && !cpu_done));

endmodule

// File: tb/sim_mi_l1_ctrl.sv
`timescale 1ns/1ps
module sim_mi_l1_ctrl;
    localparam int LA_W = 8, DATA_W = 16, ID_W = 2;

    logic clk = 1'b0, rst = 1'b1;
    logic cv = 0, fv = 0, rv = 0, rtyp = 0;
    logic [1:0] cop = 0, ftyp = 0;
    logic [LA_W-1:0] caddr = 0, faddr = 0, raddr = 0;
    logic [DATA_W-1:0] cwd = 0, rdat = 0;
    logic [ID_W-1:0] fsrc = 0;
    logic cpu_req_ready, cpu_done, req_out_valid, req_out_type, rsp_out_valid;
    logic fwd_in_ready, rsp_in_ready, proto_err;
    logic [DATA_W-1:0] cpu_done_data, req_out_data, rsp_out_data;
    logic [LA_W-1:0] req_out_addr, rsp_out_addr;
    logic [ID_W-1:0] req_out_src, req_out_dest, rsp_out_src, rsp_out_dest;
    logic got_c, got_f, got_r;
    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    mi_l1_ctrl #(.LA_W(LA_W), .DATA_W(DATA_W), .SETS(2), .WAYS(2), .ID_W(ID_W),
                 .NODE_ID(1), .DIR_BITS(1)) u0 (
        .clk, .rst,
        .cpu_req_valid(cv), .cpu_req_ready, .cpu_req_op(cop), .cpu_req_addr(caddr),
        .cpu_req_wdata(cwd), .cpu_done, .cpu_done_data,
        .req_out_valid, .req_out_type, .req_out_addr, .req_out_src, .req_out_dest, .req_out_data,
        .rsp_out_valid, .rsp_out_addr, .rsp_out_src, .rsp_out_dest, .rsp_out_data,
        .fwd_in_valid(fv), .fwd_in_ready, .fwd_in_type(ftyp), .fwd_in_addr(faddr), .fwd_in_src(fsrc),
        .rsp_in_valid(rv), .rsp_in_ready, .rsp_in_type(rtyp), .rsp_in_addr(raddr),
        .rsp_in_data(rdat), .proto_err
    );

    // {op, addr, wdata, expected completion word}
    localparam logic [41:0] HITS [8] = '{
        {2'd0, 8'h10, 16'h0000, 16'hA5A5},
        {2'd1, 8'h12, 16'h0000, 16'hBEEF},
        {2'd2, 8'h10, 16'h0001, 16'h0001},
        {2'd3, 8'h12, 16'h0202, 16'h0202},
        {2'd0, 8'h10, 16'h0000, 16'h0001},
        {2'd1, 8'h12, 16'h0000, 16'h0202},
        {2'd2, 8'h10, 16'h3333, 16'h3333},
        {2'd0, 8'h10, 16'h0000, 16'h3333}
    };

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // inputs are set at a negedge; readies sampled just after, outputs at the next negedge
    task automatic tick();
        #1;
        got_c = cpu_req_ready; got_f = fwd_in_ready; got_r = rsp_in_ready;
        @(negedge clk);
        cv = 0; fv = 0; rv = 0;
    endtask

    task automatic cpu(logic [1:0] op, logic [7:0] a, logic [15:0] wd);
        cv = 1; cop = op; caddr = a; cwd = wd; tick();
    endtask
    task automatic fwd(logic [1:0] t, logic [7:0] a, logic [1:0] src);
        fv = 1; ftyp = t; faddr = a; fsrc = src; tick();
    endtask
    task automatic rsp(logic [7:0] a, logic [15:0] d);
        rv = 1; rtyp = 0; raddr = a; rdat = d; tick();
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #400000;
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 done", cpu_done, 0);
        chk("R1 req", req_out_valid, 0);
        chk("R1 rsp", rsp_out_valid, 0);
        chk("R1 err", proto_err, 0);
        rst = 0;

        // R1/R2: first load misses
        cpu(0, 8'h10, 0);
        chk("R2 accept", got_c, 1);
        chk("R2 getx", {req_out_valid, req_out_type, req_out_addr}, {1'b1, 1'b0, 8'h10});
        chk("R2 src/dest", {req_out_src, req_out_dest}, {2'd1, 2'd0});
        chk("R2 no done", cpu_done, 0);
        // R5: other miss and same line held
        cpu(0, 8'h13, 0);
        chk("R5 other miss held", got_c, 0);
        chk("R5 one request", req_out_valid, 0);
        cpu(0, 8'h10, 0);
        chk("R5 same line held", got_c, 0);
        // R10: forwarded request held in IS
        fwd(0, 8'h10, 2);
        chk("R10 fwd held", got_f, 0);
        // R12/R3: response wins over forward and processor
        rv = 1; rtyp = 0; raddr = 8'h10; rdat = 16'hA5A5;
        fv = 1; ftyp = 0; faddr = 8'h10; fsrc = 2;
        cv = 1; cop = 0; caddr = 8'h12;
        tick();
        chk("R12 rsp served", {got_r, got_f, got_c}, 3'b100);
        chk("R3 load data", {cpu_done, cpu_done_data}, {1'b1, 16'hA5A5});
        // R3: store miss
        cpu(2, 8'h12, 16'hBEEF);
        chk("R2 store getx", {req_out_valid, req_out_type, req_out_dest}, {1'b1, 1'b0, 2'd0});
        rsp(8'h12, 16'h1111);
        chk("R3 store data", {cpu_done, cpu_done_data}, {1'b1, 16'hBEEF});

        // R4: hit table
        for (int i = 0; i < 8; i++) begin
            cpu(HITS[i][41:40], HITS[i][39:32], HITS[i][31:16]);
            chk($sformatf("R4 hit %0d accept", i), got_c, 1);
            chk($sformatf("R4 hit %0d data", i), {cpu_done, cpu_done_data}, {1'b1, HITS[i][15:0]});
            chk($sformatf("R4 hit %0d quiet", i), {req_out_valid, rsp_out_valid}, 2'b00);
        end

        // R6: forward takes modified line
        fwd(0, 8'h12, 2);
        chk("R6 accept", got_f, 1);
        chk("R6 data rsp", {rsp_out_valid, rsp_out_addr, rsp_out_dest, rsp_out_data, rsp_out_src},
            {1'b1, 8'h12, 2'd2, 16'h0202, 2'd1});
        cpu(0, 8'h12, 0);
        chk("R6 now invalid", {req_out_valid, cpu_done}, 2'b10);
        rsp(8'h12, 16'h0707);
        chk("R3 refill", cpu_done_data, 16'h0707);

        // R7: full set, victim way 0 (0x10)
        cpu(0, 8'h14, 0);
        chk("R7 not consumed", got_c, 0);
        chk("R7 putx", {req_out_valid, req_out_type, req_out_addr, req_out_data},
            {1'b1, 1'b1, 8'h10, 16'h3333});
        cpu(0, 8'h14, 0);
        chk("R5 held in MI", {got_c, req_out_valid}, 2'b00);
        // R12: forward before processor; R8 ack ends writeback
        fv = 1; ftyp = 1; faddr = 8'h10; fsrc = 0;
        cv = 1; cop = 0; caddr = 8'h14;
        tick();
        chk("R12 fwd before cpu", {got_f, got_c}, 2'b10);
        cpu(0, 8'h14, 0);
        chk("R8 miss proceeds", {got_c, req_out_valid, req_out_type, req_out_addr},
            {1'b1, 1'b1, 1'b0, 8'h14});
        rsp(8'h14, 16'h4444);
        chk("R3 after R8", cpu_done_data, 16'h4444);

        // R7/R9: next victim is way 1 (0x12), overtaken by a forward
        cpu(0, 8'h16, 0);
        chk("R7 rr advance", {req_out_valid, req_out_type, req_out_addr, req_out_data},
            {1'b1, 1'b1, 8'h12, 16'h0707});
        fwd(0, 8'h12, 3);
        chk("R9 data from copy", {got_f, rsp_out_valid, rsp_out_dest, rsp_out_data},
            {1'b1, 1'b1, 2'd3, 16'h0707});
        cpu(0, 8'h16, 0);
        chk("R9 still held", got_c, 0);
        fwd(2, 8'h12, 0);
        chk("R9 nack accepted", got_f, 1);
        chk("R9 no error", proto_err, 0);
        cpu(0, 8'h16, 0);
        chk("R9 miss proceeds", {got_c, req_out_valid, req_out_addr}, {1'b1, 1'b1, 8'h16});
        rsp(8'h16, 16'h6666);
        chk("R3 after R9", cpu_done_data, 16'h6666);

        // R11: unexpected messages
        chk("R11 clean so far", proto_err, 0);
        fwd(1, 8'h20, 0);
        chk("R11 ack consumed", got_f, 1);
        chk("R11 flag set", proto_err, 1);
        rsp(8'h30, 16'h9999);
        chk("R11 stray data", {got_r, cpu_done, proto_err}, 3'b101);
        repeat (3) @(negedge clk);
        chk("R11 sticky", proto_err, 1);

        finish_run();
    end
endmodule